// File: doc/BRIEF.md
# Printer Handshake Responder

This block stands in for a simple byte-wide printer behind a three-register port: a data byte, a status byte and a control byte. A polling driver loads a byte into the data register, pulses the strobe bit in the control register and then reads status until the printer looks ready again. The responder drives that exchange with no notion of time. The busy and acknowledge flags advance each time the status register is read.

Every byte the driver strobes out leaves the block on a one-cycle valid/data stream. When the driver sets the interrupt-enable control bit and then drops strobe, an interrupt becomes pending. A level interrupt line reports it until the next status read. Register reads are combinational from the held state in the cycle of the access. Every write and read side effect takes hold at the clock edge that ends the access.

Top module: `prn_handshake_responder`

## Requirements
- R1: After reset, status reads 0xD8 (busy bit 7, ack bit 6, online bit 4 and error-complement bit 3 set), control reads 0x0C, data reads 0xFF, irq is low and byte_valid is low.
- R2: A control write (offset 2) with the init bit (bit 2) clear sets status to exactly 0xD8.
- R3: A control write with init set, select (bit 3) set and strobe (bit 0) set clears the busy bit.
- R4: A write of the kind in R3 emits the held data byte only when the stored control strobe bit was 0 before the write. It then raises byte_valid for one cycle, in the cycle after the write, with byte_data equal to the held byte.
- R5: A strobe-set write whose stored strobe bit was already 1 emits nothing.
- R6: A control write with init and select set and strobe clear makes an interrupt pending only if the control value stored before the write had interrupt enable (bit 4) set. A pending interrupt stays pending through further control writes.
- R7: A status read (offset 1) returns the current status and clears the pending interrupt.
- R8: On a status read with busy clear and the stored strobe bit 0: if ack was set it is cleared, otherwise both ack and busy are set. Other status reads leave status unchanged.
- R9: A control read returns the last value written to control, and the handshake always uses the control value stored before the write.
- R10: irq is high exactly when an interrupt is pending and the stored control has interrupt enable set.
- R11: Reads of offsets 3 to 7 return 0xFF. Writes to status and to offsets 3 to 7 change no state.
- R12: A data write (offset 0) stores the byte without emitting it. A data read returns the held byte, or 0xFF while control direction (bit 5) is set.
- R13: A control write with init set and select clear changes neither status nor the interrupt, and emits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register offset |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data for the current access |
| irq | output | 1 | Level interrupt request |
| byte_valid | output | 1 | One-cycle pulse per emitted byte |
| byte_data | output | DATA_W | Emitted byte |

## Verification
The bench builds the responder with its defaults: ADDR_W = 3, DATA_W = 8 and HONOR_DIR = 1. The three-bit offset makes the five unused offsets reachable, so their 0xFF reads and ignored writes can be tested. With the direction option on, the data read has both of its sources, and both can be compared against the same held byte. The vector walk runs the full ack/busy read cycle twice, and it separates the pending interrupt from its enable by toggling enable while an interrupt is pending.

// File: rtl/prn_pkg.sv
package prn_pkg;
  // Register offsets (decoded by the driver).
  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;

  // Status bit positions.
  localparam int ST_BUSY   = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_ERRN   = 3;

  // Control bit positions.
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_AFD  = 1;
  localparam int CT_STB  = 0;

  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] STAT_RST =
    (8'd1 << ST_BUSY) | (8'd1 << ST_ACK) | (8'd1 << ST_ONLINE) | (8'd1 << ST_ERRN);
  localparam logic [REG_W-1:0] CTRL_RST = (8'd1 << CT_SEL) | (8'd1 << CT_INIT);

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_data;
    logic rd_stat;
    logic rd_ctrl;
  } prn_acc_t;
endpackage

// File: rtl/prn_rst_sync.sv
module prn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/prn_bus_decode.sv
module prn_bus_decode
  import prn_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output prn_acc_t          acc
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  always_comb begin
    acc = '0;
    if (acc_en) begin
      acc.wr_data = acc_wr  && (acc_addr == A_DATA);
      acc.wr_ctrl = acc_wr  && (acc_addr == A_CTRL);
      acc.rd_data = !acc_wr && (acc_addr == A_DATA);
      acc.rd_stat = !acc_wr && (acc_addr == A_STAT);
      acc.rd_ctrl = !acc_wr && (acc_addr == A_CTRL);
    end
  end
endmodule

// File: rtl/prn_status_engine.sv
module prn_status_engine
  import prn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             rd_stat,
  input  logic [REG_W-1:0] wbyte,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] stat_q,
  output logic             pend_q,
  output logic             emit
);
  logic [REG_W-1:0] ctrl_d;
  logic [REG_W-1:0] stat_d;
  logic             pend_d;
  logic             upd_en;

  assign upd_en = wr_ctrl | rd_stat;

  // Next state: the handshake is judged against the control value held
  // before the write; the new value is stored afterwards.
  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    pend_d = pend_q;
    emit   = 1'b0;
    if (wr_ctrl) begin
      if (!wbyte[CT_INIT]) begin
        stat_d = STAT_RST;
      end else if (wbyte[CT_SEL]) begin
        if (wbyte[CT_STB]) begin
          stat_d[ST_BUSY] = 1'b0;
          emit            = !ctrl_q[CT_STB];
        end else if (ctrl_q[CT_IEN]) begin
          pend_d = 1'b1;
        end
      end
      ctrl_d = wbyte;
    end
    if (rd_stat) begin
      pend_d = 1'b0;
      if (!stat_q[ST_BUSY] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_d[ST_ACK] = 1'b0;
        end else begin
          stat_d[ST_ACK]  = 1'b1;
          stat_d[ST_BUSY] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/prn_byte_port.sv
module prn_byte_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              emit,
  output logic [DATA_W-1:0] data_q,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data
);
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] out_d;

  always_comb begin
    data_d = wr_data ? wdata : data_q;
    out_d  = emit ? data_q : byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '1;
    end else if (wr_data) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_data <= '0;
    end else if (emit) begin
      byte_data <= out_d;
    end
  end
endmodule

// File: rtl/prn_handshake_responder.sv
module prn_handshake_responder
  import prn_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter bit HONOR_DIR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              irq,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data
);
  localparam logic [DATA_W-1:0] IDLE_READ = '1;

  logic             rst_sync_n;
  prn_acc_t         acc;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] stat_q;
  logic             pend_q;
  logic             emit;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_view;

  prn_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  prn_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .acc      (acc)
  );

  prn_status_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ctrl (acc.wr_ctrl),
    .rd_stat (acc.rd_stat),
    .wbyte   (acc_wdata[REG_W-1:0]),
    .ctrl_q  (ctrl_q),
    .stat_q  (stat_q),
    .pend_q  (pend_q),
    .emit    (emit)
  );

  prn_byte_port #(.DATA_W(DATA_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_data    (acc.wr_data),
    .wdata      (acc_wdata),
    .emit       (emit),
    .data_q     (data_q),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  generate
    if (HONOR_DIR) begin : g_dir
      assign data_view = ctrl_q[CT_DIR] ? IDLE_READ : data_q;
    end else begin : g_nodir
      assign data_view = data_q;
    end
  endgenerate

  always_comb begin
    acc_rdata = IDLE_READ;
    if (acc.rd_data) acc_rdata = data_view;
    if (acc.rd_stat) acc_rdata = DATA_W'(stat_q);
    if (acc.rd_ctrl) acc_rdata = DATA_W'(ctrl_q);
  end

  assign irq = pend_q & ctrl_q[CT_IEN];
endmodule

// File: rtl/prn_handshake_checker.sv
module prn_handshake_checker
  import prn_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              irq,
  input logic              byte_valid,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  stat_q
);
  logic ctrl_wr, data_wr, stat_rd;
  assign ctrl_wr = acc_en && acc_wr && (acc_addr == ADDR_W'(OFS_CTRL));
  assign data_wr = acc_en && acc_wr && (acc_addr == ADDR_W'(OFS_DATA));
  assign stat_rd = acc_en && !acc_wr && (acc_addr == ADDR_W'(OFS_STAT));

  p_emit_after_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(ctrl_wr));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[CT_IEN]);

  p_stat_read_drops_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !irq);

  p_init_low_restores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !acc_wdata[CT_INIT]) |=> (stat_q == STAT_RST));

  p_strobe_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && acc_wdata[CT_INIT] && acc_wdata[CT_SEL] && acc_wdata[CT_STB])
      |=> !stat_q[ST_BUSY]);

  p_ctrl_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == $past(acc_wdata[REG_W-1:0])));

  p_data_write_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !byte_valid);
endmodule

bind prn_handshake_responder prn_handshake_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_addr   (acc_addr),
  .acc_wdata  (acc_wdata),
  .irq        (irq),
  .byte_valid (byte_valid),
  .ctrl_q     (ctrl_q),
  .stat_q     (stat_q)
);

// File: tb/prn_handshake_responder_test.sv
module prn_handshake_responder_test;
  localparam int NV = 33;
  // {wr, addr[2:0], wdata, exp_rdata, exp_irq, exp_emit, exp_byte}
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'h41, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h41, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h1D, 8'h00, 1'b0, 1'b1, 8'h41},
    {1'b0, 3'd2, 8'h00, 8'h1D, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b1, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h58, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h18, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd0, 8'h5A, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h0D, 8'h00, 1'b0, 1'b1, 8'h5A},
    {1'b1, 3'd2, 8'h0D, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h0C, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b1, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h0C, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b1, 1'b0, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'hFF, 1'b1, 1'b0, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h58, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h18, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h0D, 8'h00, 1'b0, 1'b1, 8'h5A},
    {1'b1, 3'd2, 8'h09, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h04, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h05, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h2C, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd2, 8'h0C, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b1, 3'd6, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00}
  };

  logic       clk;
  logic       rst_n;
  logic       acc_en;
  logic       acc_wr;
  logic [2:0] acc_addr;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic       irq;
  logic       byte_valid;
  logic [7:0] byte_data;

  int checks = 0;
  int fails  = 0;

  prn_handshake_responder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .irq        (irq),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Write: driven for one cycle; returns at the negedge after the update edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    #1;
  endtask

  // Read: compares the combinational read data before the update edge.
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    #1;
    chk(req, acc_rdata, exp);
    @(negedge clk);
    acc_en = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, NV);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 byte_valid", {7'd0, byte_valid}, 8'h00);
    rd(3'd1, 8'hD8, "R1 status");
    rd(3'd2, 8'h0C, "R1 control");
    rd(3'd0, 8'hFF, "R1 data");

    // Table walk (R4 emit, R8 status cycle, R9 readback, R10 irq, R11, R12)
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      @(negedge clk);
      acc_en = 1'b1; acc_wr = v[29]; acc_addr = v[28:26]; acc_wdata = v[25:18];
      #1;
      if (!v[29]) begin
        case (v[28:26])
          3'd0:    chk("R12 data read", acc_rdata, v[17:10]);
          3'd1:    chk("R8 status read", acc_rdata, v[17:10]);
          3'd2:    chk("R9 control read", acc_rdata, v[17:10]);
          default: chk("R11 unused read", acc_rdata, v[17:10]);
        endcase
      end
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
      #1;
      chk("R10 irq", {7'd0, irq}, {7'd0, v[9]});
      chk("R4 byte_valid", {7'd0, byte_valid}, {7'd0, v[8]});
      if (v[8]) chk("R4 byte_data", byte_data, v[7:0]);
      @(negedge clk);
      #1;
      chk("R4 pulse width", {7'd0, byte_valid}, 8'h00);
    end

    // Directed corner cases from a fresh reset
    do_reset();
    @(negedge clk);
    wr(3'd2, 8'h0D);
    chk("R4 emit reset byte", {7'd0, byte_valid}, 8'h01);
    chk("R4 emit value", byte_data, 8'hFF);
    rd(3'd1, 8'h58, "R3 busy cleared");
    wr(3'd2, 8'h0D);
    chk("R5 no repeat emit", {7'd0, byte_valid}, 8'h00);
    wr(3'd2, 8'h1C);
    chk("R6 prior enable clear", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'h1C);
    chk("R6 prior enable set", {7'd0, irq}, 8'h01);
    rd(3'd1, 8'h58, "R7 status value");
    chk("R7 irq cleared", {7'd0, irq}, 8'h00);
    rd(3'd1, 8'h18, "R8 ack dropped");
    wr(3'd2, 8'h18);
    rd(3'd1, 8'hD8, "R2 init low");
    wr(3'd2, 8'h04);
    wr(3'd2, 8'h05);
    chk("R13 no emit", {7'd0, byte_valid}, 8'h00);
    rd(3'd1, 8'hD8, "R13 status kept");
    wr(3'd2, 8'h14);
    wr(3'd2, 8'h14);
    chk("R13 no pending", {7'd0, irq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule